// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Address-Space Tags

This block keeps a small set of recent virtual-page to physical-frame translations so that most memory accesses need no page-table lookup. Each lookup compares a virtual page number and the current address-space tag against every entry at once. When an entry matches, the frame number and a protection verdict for the requested access type come back in the same cycle. When nothing matches, the block raises a miss and leaves the page walk to logic outside it. That logic then returns the translation through the fill port.

Entries from several address spaces can live side by side, because an entry answers only to its own tag. A full flush wipes every entry, for example when tags are not in use and a new page table becomes active. A tag flush removes only the entries of one address space. On a fill, an invalid slot is taken first. When every slot is valid, a round-robin pointer names the entry to evict. A fill for a translation that is already present rewrites that entry in place, so the same page and tag never appear twice.

Each cycle the block performs one update operation, chosen by priority from its inputs:
- `OP_FLUSH_ALL`: wipe every entry.
- `OP_FLUSH_ASID`: wipe every entry tagged with the given address space.
- `OP_FILL`: write one translation.
- `OP_IDLE`: change nothing.

Top module: `xlat_cache`

## Requirements
- R1: A lookup (`lk_valid`=1) whose page number and tag equal those of a valid entry sets `lk_hit` in the same cycle and drives that entry's frame on `lk_pfn`.
- R2: A lookup that matches no valid entry sets `lk_miss` and clears `lk_hit` and `lk_fault`, with `lk_pfn`=0. With `lk_valid`=0, `lk_hit`, `lk_miss` and `lk_fault` are all 0.
- R3: A hit needs the page number and the tag to match. Two entries with the same page number and different tags each hit only for their own tag.
- R4: Permission bits are bit0 read, bit1 write and bit2 execute. Access codes are 0 read, 1 write, 2 execute, and code 3 is never permitted. On a hit whose entry lacks the bit for the access, `lk_fault`=1 and the frame is still driven.
- R5: A fill of a translation that is not yet present goes to the lowest-numbered invalid entry when one exists. The round-robin pointer does not move.
- R6: When all entries are valid, a fill of a new translation replaces the entry named by the round-robin pointer. The pointer is 0 after reset and then steps by one, wrapping after the last entry, on each such eviction only.
- R7: A fill whose page number and tag equal those of a valid entry rewrites that entry's frame and permissions, takes no other slot, and leaves the pointer unchanged.
- R8: `flush_all` invalidates every entry, so no lookup hits from the next cycle on.
- R9: `flush_asid_en` invalidates exactly the entries whose tag equals `flush_asid`. Entries with other tags keep hitting.
- R10: Operations have the priority flush_all > tag flush > fill. A lower-priority request in the same cycle is dropped.
- R11: After reset every entry is invalid and the pointer is 0.
- R12: A fill or flush takes effect at the clock edge. A lookup in the same cycle sees the old contents, and a lookup in the next cycle sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_miss | output | 1 | Lookup matched no entry |
| lk_fault | output | 1 | Hit, but access not permitted |
| lk_pfn | output | PFN_W | Frame number on hit, else 0 |
| fill_valid | input | 1 | Insert a translation |
| fill_vpn | input | VPN_W | Page number to insert |
| fill_asid | input | ASID_W | Tag to insert |
| fill_pfn | input | PFN_W | Frame number to insert |
| fill_perm | input | 3 | Permissions {exec, write, read} |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_en | input | 1 | Invalidate entries of one tag |
| flush_asid | input | ASID_W | Tag to invalidate |

## Verification
The bench builds the block with four entries, 6-bit page numbers, 8-bit frames and 2-bit tags. With only four entries, a handful of fills fills the cache, so the pointer wraps and evictions happen often. With only four tags, random traffic keeps producing pages that share a number but carry different tags, and frequent tag flushes. Random page numbers are drawn from a small range so that duplicate fills and hits both happen often.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_FLUSH_ALL,
        OP_FLUSH_ASID,
        OP_FILL
    } op_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;

    function automatic logic perm_ok(input logic [2:0] perm, input acc_e acc);
        logic ok;
        unique case (acc)
            ACC_READ:  ok = perm[PERM_R];
            ACC_WRITE: ok = perm[PERM_W];
            ACC_EXEC:  ok = perm[PERM_X];
            ACC_RSVD:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlat_cam_match.sv
module xlat_cam_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tab,
    input  logic [ENTRIES-1:0][ASID_W-1:0] asid_tab,
    input  logic [VPN_W-1:0]               key_vpn,
    input  logic [ASID_W-1:0]              key_asid,
    output logic [ENTRIES-1:0]             match
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = valid[i]
                        && (vpn_tab[i]  == key_vpn)
                        && (asid_tab[i] == key_asid);
    end

endmodule

// File: rtl/xlat_victim_sel.sv
module xlat_victim_sel #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   victim,
    output logic               full
);

    always_comb begin
        full   = &valid;
        victim = rr_ptr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                victim = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/xlat_entry_array.sv
module xlat_entry_array
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  op_e                            op,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [VPN_W-1:0]               wr_vpn,
    input  logic [ASID_W-1:0]              wr_asid,
    input  logic [PFN_W-1:0]               wr_pfn,
    input  logic [2:0]                     wr_perm,
    input  logic [ASID_W-1:0]              kill_asid,
    output logic [ENTRIES-1:0]             valid,
    output logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tab,
    output logic [ENTRIES-1:0][ASID_W-1:0] asid_tab,
    output logic [ENTRIES-1:0][PFN_W-1:0]  pfn_tab,
    output logic [ENTRIES-1:0][2:0]        perm_tab
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic              v_q;
        logic [VPN_W-1:0]  vpn_q;
        logic [ASID_W-1:0] asid_q;
        logic [PFN_W-1:0]  pfn_q;
        logic [2:0]        perm_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q    <= 1'b0;
                vpn_q  <= '0;
                asid_q <= '0;
                pfn_q  <= '0;
                perm_q <= '0;
            end else begin
                unique case (op)
                    OP_IDLE: ;
                    OP_FLUSH_ALL: v_q <= 1'b0;
                    OP_FLUSH_ASID: begin
                        if (asid_q == kill_asid) begin
                            v_q <= 1'b0;
                        end
                    end
                    OP_FILL: begin
                        if (wr_idx == IDX_W'(i)) begin
                            v_q    <= 1'b1;
                            vpn_q  <= wr_vpn;
                            asid_q <= wr_asid;
                            pfn_q  <= wr_pfn;
                            perm_q <= wr_perm;
                        end
                    end
                endcase
            end
        end

        assign valid[i]    = v_q;
        assign vpn_tab[i]  = vpn_q;
        assign asid_tab[i] = asid_q;
        assign pfn_tab[i]  = pfn_q;
        assign perm_tab[i] = perm_q;
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int ASID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_acc,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [PFN_W-1:0]  lk_pfn,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [2:0]        fill_perm,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
    logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
    logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn;
    logic [ENTRIES-1:0][2:0]        ent_perm;

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fill_match;
    logic [IDX_W-1:0]   lk_idx;
    logic [IDX_W-1:0]   dup_idx;
    logic [IDX_W-1:0]   vict_idx;
    logic [IDX_W-1:0]   wr_idx;
    logic [IDX_W-1:0]   rr_q;
    logic               all_full;
    logic               fill_dup;
    op_e                op;

    // Operation select: fixed priority among the update requests.
    always_comb begin
        if (flush_all) begin
            op = OP_FLUSH_ALL;
        end else if (flush_asid_en) begin
            op = OP_FLUSH_ASID;
        end else if (fill_valid) begin
            op = OP_FILL;
        end else begin
            op = OP_IDLE;
        end
    end

    xlat_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cmp (
        .valid    (ent_valid),
        .vpn_tab  (ent_vpn),
        .asid_tab (ent_asid),
        .key_vpn  (lk_vpn),
        .key_asid (lk_asid),
        .match    (lk_match)
    );

    xlat_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cmp (
        .valid    (ent_valid),
        .vpn_tab  (ent_vpn),
        .asid_tab (ent_asid),
        .key_vpn  (fill_vpn),
        .key_asid (fill_asid),
        .match    (fill_match)
    );

    xlat_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
        .valid  (ent_valid),
        .rr_ptr (rr_q),
        .victim (vict_idx),
        .full   (all_full)
    );

    // One-hot to index for both match vectors (entries are kept unique).
    always_comb begin
        lk_idx  = '0;
        dup_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_idx = lk_idx | IDX_W'(i);
            end
            if (fill_match[i]) begin
                dup_idx = dup_idx | IDX_W'(i);
            end
        end
    end

    assign fill_dup = |fill_match;
    assign wr_idx   = fill_dup ? dup_idx : vict_idx;

    xlat_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .ASID_W  (ASID_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .wr_idx    (wr_idx),
        .wr_vpn    (fill_vpn),
        .wr_asid   (fill_asid),
        .wr_pfn    (fill_pfn),
        .wr_perm   (fill_perm),
        .kill_asid (flush_asid),
        .valid     (ent_valid),
        .vpn_tab   (ent_vpn),
        .asid_tab  (ent_asid),
        .pfn_tab   (ent_pfn),
        .perm_tab  (ent_perm)
    );

    // Replacement pointer: moves only when a valid entry is evicted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else begin
            unique case (op)
                OP_FILL: begin
                    if (!fill_dup && all_full) begin
                        rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
                    end
                end
                OP_IDLE, OP_FLUSH_ALL, OP_FLUSH_ASID: ;
            endcase
        end
    end

    // Lookup outputs.
    always_comb begin
        lk_hit   = lk_valid && (|lk_match);
        lk_miss  = lk_valid && !(|lk_match);
        lk_pfn   = lk_hit ? ent_pfn[lk_idx] : '0;
        lk_fault = lk_hit && !perm_ok(ent_perm[lk_idx], acc_e'(lk_acc));
    end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int ASID_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic              lk_fault,
    input logic [PFN_W-1:0]  lk_pfn,
    input logic              fill_valid,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [ASID_W-1:0] fill_asid,
    input logic [PFN_W-1:0]  fill_pfn,
    input logic              flush_all,
    input logic              flush_asid_en,
    input logic [ASID_W-1:0] flush_asid,
    input logic [ENTRIES-1:0] lk_match
);

    logic fill_go;
    assign fill_go = fill_valid && !flush_all && !flush_asid_en;

    // R7: fills never create a second copy of a translation
    assert_no_dup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R4: a fault only accompanies a hit
    assert_fault_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    // R2: a miss carries no hit and a zero frame
    assert_miss_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (!lk_hit && !lk_fault && lk_pfn == '0));

    // R11: nothing hits in the first cycle out of reset
    assert_reset_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit);

    // R12: a performed fill is visible on the next cycle
    assert_fill_visible_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |=> (!(lk_valid && lk_vpn == $past(fill_vpn) && lk_asid == $past(fill_asid))
                     || (lk_hit && lk_pfn == $past(fill_pfn))));

    // R8: nothing hits right after a full flush
    assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !lk_hit);

    // R9: the flushed tag no longer hits
    assert_flush_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_asid_en && !flush_all) |=> !(lk_hit && lk_asid == $past(flush_asid)));

    // R10: a fill dropped by a full flush leaves nothing behind
    assert_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && fill_valid) |=> !(lk_hit && lk_vpn == $past(fill_vpn)
                                        && lk_asid == $past(fill_asid)));

endmodule

bind xlat_cache xlat_cache_chk #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W),
    .ASID_W  (ASID_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_vpn        (lk_vpn),
    .lk_asid       (lk_asid),
    .lk_hit        (lk_hit),
    .lk_miss       (lk_miss),
    .lk_fault      (lk_fault),
    .lk_pfn        (lk_pfn),
    .fill_valid    (fill_valid),
    .fill_vpn      (fill_vpn),
    .fill_asid     (fill_asid),
    .fill_pfn      (fill_pfn),
    .flush_all     (flush_all),
    .flush_asid_en (flush_asid_en),
    .flush_asid    (flush_asid),
    .lk_match      (lk_match)
);

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb;

    localparam int N  = 4;
    localparam int VW = 6;
    localparam int PW = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] lk_asid = '0;
    logic [1:0]    lk_acc = '0;
    logic          lk_hit, lk_miss, lk_fault;
    logic [PW-1:0] lk_pfn;
    logic          fill_valid = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [AW-1:0] fill_asid = '0;
    logic [PW-1:0] fill_pfn = '0;
    logic [2:0]    fill_perm = '0;
    logic          flush_all = 1'b0;
    logic          flush_asid_en = 1'b0;
    logic [AW-1:0] flush_asid = '0;

    int checks = 0;
    int fails  = 0;

    bit            m_v    [N];
    logic [VW-1:0] m_vpn  [N];
    logic [AW-1:0] m_asid [N];
    logic [PW-1:0] m_pfn  [N];
    logic [2:0]    m_perm [N];
    int            m_rr;

    xlat_cache #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_pfn(lk_pfn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
    );

    always #4 clk = ~clk;

    function automatic bit allows(input logic [2:0] p, input logic [1:0] a);
        case (a)
            2'd0:    return p[0];
            2'd1:    return p[1];
            2'd2:    return p[2];
            default: return 1'b0;
        endcase
    endfunction

    function automatic int find(input logic [VW-1:0] v, input logic [AW-1:0] a);
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_vpn[i] == v && m_asid[i] == a) return i;
        end
        return -1;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        m_rr = 0;
    endtask

    task automatic step(input string tag,
                        input bit lv, input logic [VW-1:0] v, input logic [AW-1:0] a,
                        input logic [1:0] ac,
                        input bit fv, input logic [VW-1:0] fvp, input logic [AW-1:0] fa,
                        input logic [PW-1:0] fp, input logic [2:0] fpm,
                        input bit fall, input bit fae, input logic [AW-1:0] fka);
        int  k;
        bit  e_hit, e_miss, e_fault;
        logic [PW-1:0] e_pfn;
        @(negedge clk);
        lk_valid = lv; lk_vpn = v; lk_asid = a; lk_acc = ac;
        fill_valid = fv; fill_vpn = fvp; fill_asid = fa; fill_pfn = fp; fill_perm = fpm;
        flush_all = fall; flush_asid_en = fae; flush_asid = fka;
        #1;
        k       = find(v, a);
        e_hit   = lv && (k >= 0);
        e_miss  = lv && (k < 0);
        e_pfn   = e_hit ? m_pfn[k] : '0;
        e_fault = e_hit && !allows(m_perm[k], ac);
        checks++;
        if ({lk_hit, lk_miss, lk_fault, lk_pfn} !== {e_hit, e_miss, e_fault, e_pfn}) begin
            fails++;
            $display("FAIL %s: hit/miss/fault/pfn actual=%b/%b/%b/%h expected=%b/%b/%b/%h",
                     tag, lk_hit, lk_miss, lk_fault, lk_pfn, e_hit, e_miss, e_fault, e_pfn);
        end
        @(posedge clk);
        #1;
        if (fall) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        end else if (fae) begin
            for (int i = 0; i < N; i++) if (m_asid[i] == fka) m_v[i] = 1'b0;
        end else if (fv) begin
            k = find(fvp, fa);
            if (k < 0) begin
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) k = i;
                if (k < 0) begin
                    k = m_rr;
                    m_rr = (m_rr + 1) % N;
                end
            end
            m_v[k] = 1'b1; m_vpn[k] = fvp; m_asid[k] = fa;
            m_pfn[k] = fp; m_perm[k] = fpm;
        end
    endtask

    task automatic look(input string tag, input logic [VW-1:0] v,
                        input logic [AW-1:0] a, input logic [1:0] ac);
        step(tag, 1'b1, v, a, ac, 1'b0, '0, '0, '0, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic fill(input string tag, input logic [VW-1:0] v, input logic [AW-1:0] a,
                        input logic [PW-1:0] p, input logic [2:0] pm);
        step(tag, 1'b1, v, a, 2'd0, 1'b1, v, a, p, pm, 1'b0, 1'b0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL all requirements: watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        look("R11 reset empty", 6'd0, 2'd0, 2'd0);
        look("R11 reset empty", 6'd5, 2'd1, 2'd0);
        fill("R12 same-cycle old view", 6'd5, 2'd1, 8'h21, 3'b001);
        look("R1 hit read", 6'd5, 2'd1, 2'd0);
        look("R4 write fault", 6'd5, 2'd1, 2'd1);
        look("R4 exec fault", 6'd5, 2'd1, 2'd2);
        look("R4 reserved code fault", 6'd5, 2'd1, 2'd3);
        look("R3 other tag miss", 6'd5, 2'd2, 2'd0);
        fill("R3 same page new tag", 6'd5, 2'd2, 8'h33, 3'b111);
        look("R3 tag2 hit", 6'd5, 2'd2, 2'd2);
        look("R3 tag1 hit", 6'd5, 2'd1, 2'd0);
        fill("R7 duplicate fill", 6'd5, 2'd1, 8'h44, 3'b011);
        look("R7 rewritten frame", 6'd5, 2'd1, 2'd1);
        fill("R5 fill free slot", 6'd6, 2'd1, 8'h55, 3'b001);
        fill("R5 fill last slot", 6'd7, 2'd1, 8'h66, 3'b001);
        fill("R6 evict slot0", 6'd8, 2'd1, 8'h77, 3'b001);
        look("R6 evicted entry misses", 6'd5, 2'd1, 2'd0);
        look("R7 slot not consumed", 6'd6, 2'd1, 2'd0);
        look("R6 tag2 entry survives", 6'd5, 2'd2, 2'd0);
        fill("R6 evict slot1", 6'd9, 2'd1, 8'h88, 3'b001);
        look("R6 second eviction", 6'd5, 2'd2, 2'd0);
        fill("R6 pointer step", 6'd10, 2'd3, 8'h99, 3'b001);
        fill("R6 pointer wrap", 6'd11, 2'd3, 8'hAA, 3'b001);
        step("R9 tag flush", 1'b1, 6'd8, 2'd1, 2'd0, 1'b0, '0, '0, '0, '0, 1'b0, 1'b1, 2'd1);
        look("R9 flushed tag miss", 6'd8, 2'd1, 2'd0);
        look("R9 other tag kept", 6'd11, 2'd3, 2'd0);
        fill("R5 hole reused", 6'd12, 2'd0, 8'hBB, 3'b100);
        fill("R5 hole reused", 6'd13, 2'd0, 8'hCC, 3'b100);
        look("R5 no eviction of live entry", 6'd10, 2'd3, 2'd0);
        look("R5 no eviction of live entry", 6'd11, 2'd3, 2'd0);
        step("R10 flush_all beats fill", 1'b0, '0, '0, 2'd0, 1'b1, 6'd20, 2'd2, 8'h12, 3'b111,
             1'b1, 1'b0, '0);
        look("R10 dropped fill", 6'd20, 2'd2, 2'd0);
        look("R8 all gone", 6'd12, 2'd0, 2'd2);
        fill("R8 refill", 6'd21, 2'd1, 8'h13, 3'b010);
        step("R10 tag flush beats fill", 1'b0, '0, '0, 2'd0, 1'b1, 6'd22, 2'd2, 8'h14, 3'b111,
             1'b0, 1'b1, 2'd3);
        look("R10 dropped fill", 6'd22, 2'd2, 2'd0);
        look("R10 other tag unaffected", 6'd21, 2'd1, 2'd1);
        step("R2 idle lookup", 1'b0, 6'd21, 2'd1, 2'd1, 1'b0, '0, '0, '0, '0, 1'b0, 1'b0, '0);

        for (int n = 0; n < 4000; n++) begin
            int r;
            bit fv, fa_b, fe;
            r    = int'($urandom_range(0, 99));
            fv   = (r < 45);
            fa_b = (r >= 97);
            fe   = (r >= 90) && (r < 97);
            step("R1 R2 R3 R4 R5 R6 R7 random", $urandom_range(0, 9) != 0,
                 VW'($urandom_range(0, 9)), AW'($urandom), 2'($urandom),
                 fv, VW'($urandom_range(0, 9)), AW'($urandom), PW'($urandom), 3'($urandom),
                 fa_b, fe, AW'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule